// File: doc/BRIEF.md
# Keyed watchdog with early-warning timer

This block is a byte-wide, register-mapped supervision timer built from two independent down-counters. The reset counter counts toward zero. When it gets there it requests a system reset. Software keeps it from firing by writing a fixed key byte, and any other byte leaves it alone. The warning counter is a second, longer-resolution timer that software restarts along with every key write. It is given a shorter deadline than the reset counter, so a stalled program raises the warning interrupt first. The handler can then record state before the reset arrives.

Both counters step on ticks from a prescaler whose period is a base divider shifted left by a 2-bit select. The reset counter needs two things before it moves. Its prescaler channel must have been started by a write to the channel start address. Its load value must have been armed by a write to the low load byte. A configuration register holds three settings: key checking on or off, per-clock or prescaled counting for the reset counter, and a lock code. Once the lock code is set, the configuration side is frozen until the next reset. Key writes and warning control writes are the only writes that still take effect. A control register may grant permission to pause the reset counter. With the control register cleared, nothing can stop the counter.

Top module: `kwd_top`

## Requirements
- R1: After reset, `rst_req` and `warn_irq` are low and every readable register (CFG, CTRL, the load bytes, the count bytes, STAT) reads 0x00.
- R2: A write to the low reset-load byte (address 0x3) loads the reset counter with {high byte at 0x4, written byte} and marks it running. The count drops by one per step. On the step that takes it from 1 (or 0) to zero, `rst_req` goes high for exactly one clock.
- R3: While the prescaler channel has not been started by a write to address 0x7, the reset counter does not step and `rst_req` stays low.
- R4: CFG bit 5 selects the reset counter's step source. With bit 5 = 0 it steps on every clock once the channel is running. With bit 5 = 1 it steps once per channel tick. A tick comes every BASE_DIV << CPSR[1:0] clocks counted from the channel start write, so a load of N written two clocks after the start expires N*period-2 clocks after the load.
- R5: With CFG bit 4 = 1, a write of 0x5C to the key address 0x2 reloads the reset counter from its load registers. Any other byte written there leaves the count unchanged.
- R6: With CFG bit 4 = 0, a write of any byte to the key address reloads the reset counter.
- R7: A write to the warning control address 0xB does three things. It sets the warning enable from bit 0. If bit 1 is set, it reloads the 24-bit warning count from bytes 0x8 (low), 0x9 and 0xA (high). It clears the warning flag. An enabled warning counter steps once every BASE_DIV << WPSR[1:0] clocks from that write. After L steps it sets `warn_irq`, which stays high until the next warning control write.
- R8: When CFG[3:0] = 0xF the block is locked until reset. Writes to CFG (0x0), CTRL (0x1), the load bytes, WPSR (0x5), CPSR (0x6) and the channel start address are ignored. Key writes and warning control writes still act.
- R9: The reset counter holds its count while CTRL[1:0] = 11. Any other CTRL value, including 0x00 and 0x02, lets it keep counting.
- R10: Once expired, the reset counter stays at zero, `rst_req` stays low, and further key or load writes have no effect until reset.
- R11: Reads are combinational from `bus_addr`: 0x0 CFG, 0x1 CTRL, 0x3/0x4 reset load low/high, 0x5 WPSR, 0x6 CPSR, 0x8-0xA warning load, 0xB warning enable in bit 0, 0xC/0xD reset count low/high, 0xE STAT. STAT carries the warning flag in bit 0, expired in bit 1, reset counter running in bit 2 and channel running in bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_addr | input | 4 | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| warn_irq | output | 1 | Sticky early-warning interrupt |
| rst_req | output | 1 | One-clock reset request on expiry |

## Verification
The reset counter is run in per-clock mode so the expiry edge can be predicted to the exact clock. It is then run under two prescaler selects, which tells a wrong tick period apart from a wrong phase at the channel start. Key writes are tried in three forms: random non-key bytes, the real key, and arbitrary bytes with key checking off. Together these separate a key comparator that is too strict, one that is too loose, and one that ignores the enable. A service-then-stall sequence with the lock set shows that the warning arrives ahead of the reset, and that locking leaves servicing intact. Bursts of random register writes, some of which set the lock code, are compared by readback against a shadow model of the lock rule.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  typedef enum logic [3:0] {
    A_CFG     = 4'h0,
    A_CTRL    = 4'h1,
    A_KEY     = 4'h2,
    A_RLD_LO  = 4'h3,
    A_RLD_HI  = 4'h4,
    A_WPSR    = 4'h5,
    A_CPSR    = 4'h6,
    A_CHSTART = 4'h7,
    A_WLD0    = 4'h8,
    A_WLD1    = 4'h9,
    A_WLD2    = 4'hA,
    A_WCTL    = 4'hB,
    A_RCNT_LO = 4'hC,
    A_RCNT_HI = 4'hD,
    A_STAT    = 4'hE
  } kwd_addr_e;

  typedef struct packed {
    logic [3:0] rsv;
    logic       chan_run;
    logic       rst_run;
    logic       expired;
    logic       warn_flag;
  } kwd_stat_t;

  // clocks between ticks for a given select
  function automatic int unsigned tick_period(input int unsigned base, input logic [1:0] sel);
    return base << sel;
  endfunction

  // a key write counts when checking is off or the byte matches
  function automatic logic key_accept(input logic match_en, input logic [7:0] val,
                                      input logic [7:0] key);
    return !match_en || (val == key);
  endfunction

  function automatic logic lock_code(input logic [7:0] cfg);
    return cfg[3:0] == 4'hF;
  endfunction

  function automatic logic halt_code(input logic [7:0] ctrl);
    return ctrl[1:0] == 2'b11;
  endfunction

endpackage

// File: rtl/kwd_prescale.sv
module kwd_prescale #(
  parameter int unsigned BASE_DIV = 2,
  parameter int unsigned CW       = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  always_comb last = CW'(kwd_pkg::tick_period(BASE_DIV, sel) - 1);

  assign tick = run && !restart && (cnt_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run || restart)  cnt_q <= '0;
    else if (cnt_q >= last)    cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/kwd_regs.sv
module kwd_regs import kwd_pkg::*; #(
  parameter int unsigned RST_W   = 16,
  parameter int unsigned WARN_W  = 24,
  parameter logic [7:0]  KEY_VAL = 8'h5C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [3:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [RST_W-1:0]  rcnt,
  input  kwd_stat_t         stat,
  input  logic              warn_en,
  output logic [7:0]        cfg_q,
  output logic [7:0]        ctrl_q,
  output logic [7:0]        wpsr_q,
  output logic [7:0]        cpsr_q,
  output logic [RST_W-1:0]  rld_val,
  output logic [RST_W-1:0]  rld_next,
  output logic [WARN_W-1:0] wld_val,
  output logic              chan_run,
  output logic              locked,
  output logic              rld_wr,
  output logic              key_hit,
  output logic              wctl_wr,
  output logic              chstart_wr
);
  localparam int unsigned RB = RST_W / 8;
  localparam int unsigned WB = WARN_W / 8;

  logic wr_open;

  assign locked     = lock_code(cfg_q);
  assign wr_open    = bus_we && !locked;
  assign rld_wr     = wr_open && (bus_addr == A_RLD_LO);
  assign chstart_wr = wr_open && (bus_addr == A_CHSTART);
  assign wctl_wr    = bus_we && (bus_addr == A_WCTL);
  assign key_hit    = bus_we && (bus_addr == A_KEY) && key_accept(cfg_q[4], bus_wdata, KEY_VAL);

  // value loaded by a low-byte write: upper bytes held, low byte from the bus
  generate
    for (genvar g = 0; g < RB; g++) begin : g_next
      if (g == 0) begin : g_lo
        assign rld_next[7:0] = bus_wdata;
      end else begin : g_hi
        assign rld_next[g*8 +: 8] = rld_val[g*8 +: 8];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      ctrl_q   <= '0;
      wpsr_q   <= '0;
      cpsr_q   <= '0;
      rld_val  <= '0;
      wld_val  <= '0;
      chan_run <= 1'b0;
    end else if (wr_open) begin
      if (bus_addr == A_CFG)     cfg_q    <= bus_wdata;
      if (bus_addr == A_CTRL)    ctrl_q   <= bus_wdata;
      if (bus_addr == A_WPSR)    wpsr_q   <= bus_wdata;
      if (bus_addr == A_CPSR)    cpsr_q   <= bus_wdata;
      if (bus_addr == A_CHSTART) chan_run <= 1'b1;
      for (int i = 0; i < RB; i++)
        if (bus_addr == 4'(A_RLD_LO + i)) rld_val[i*8 +: 8] <= bus_wdata;
      for (int i = 0; i < WB; i++)
        if (bus_addr == 4'(A_WLD0 + i)) wld_val[i*8 +: 8] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CFG:   bus_rdata = cfg_q;
      A_CTRL:  bus_rdata = ctrl_q;
      A_WPSR:  bus_rdata = wpsr_q;
      A_CPSR:  bus_rdata = cpsr_q;
      A_WCTL:  bus_rdata = {7'd0, warn_en};
      A_STAT:  bus_rdata = stat;
      default: bus_rdata = '0;
    endcase
    for (int i = 0; i < RB; i++) begin
      if (bus_addr == 4'(A_RLD_LO + i))  bus_rdata = rld_val[i*8 +: 8];
      if (bus_addr == 4'(A_RCNT_LO + i)) bus_rdata = rcnt[i*8 +: 8];
    end
    for (int i = 0; i < WB; i++)
      if (bus_addr == 4'(A_WLD0 + i)) bus_rdata = wld_val[i*8 +: 8];
  end
endmodule

// File: rtl/kwd_rstcnt.sv
module kwd_rstcnt #(
  parameter int unsigned RST_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RST_W-1:0] load_val,
  input  logic             key_hit,
  input  logic [RST_W-1:0] reload_val,
  input  logic             tick,
  input  logic             halt,
  output logic [RST_W-1:0] rcnt,
  output logic             run,
  output logic             expired,
  output logic             expire_evt,
  output logic             rst_req
);
  logic load_ok, key_ok, step, at_end;

  assign load_ok    = load && !expired;
  assign key_ok     = key_hit && !expired;
  assign step       = run && !expired && !halt && tick;
  assign at_end     = rcnt <= RST_W'(1);
  assign expire_evt = step && !load_ok && !key_ok && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt    <= '0;
      run     <= 1'b0;
      expired <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= expire_evt;
      if (load_ok) begin
        rcnt <= load_val;
        run  <= 1'b1;
      end else if (key_ok) begin
        rcnt <= reload_val;
      end else if (step) begin
        if (at_end) begin
          rcnt    <= '0;
          expired <= 1'b1;
        end else begin
          rcnt <= rcnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/kwd_warncnt.sv
module kwd_warncnt #(
  parameter int unsigned WARN_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [1:0]        ctl_data,
  input  logic [WARN_W-1:0] load_val,
  input  logic              tick,
  output logic              en,
  output logic              flag
);
  logic [WARN_W-1:0] wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0;
      en   <= 1'b0;
      flag <= 1'b0;
    end else if (ctl_wr) begin
      en   <= ctl_data[0];
      flag <= 1'b0;
      if (ctl_data[1]) wcnt <= load_val;
    end else if (en && tick) begin
      if (wcnt <= WARN_W'(1)) begin
        wcnt <= '0;
        en   <= 1'b0;
        flag <= 1'b1;
      end else begin
        wcnt <= wcnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/kwd_top.sv
module kwd_top import kwd_pkg::*; #(
  parameter int unsigned RST_W    = 16,
  parameter int unsigned WARN_W   = 24,
  parameter int unsigned BASE_DIV = 2,
  parameter logic [7:0]  KEY_VAL  = 8'h5C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       warn_irq,
  output logic       rst_req
);
  localparam int unsigned PSC_W = $clog2(BASE_DIV * 8);

  logic [7:0]        cfg_q, ctrl_q, wpsr_q, cpsr_q;
  logic [RST_W-1:0]  rld_val, rld_next, rcnt;
  logic [WARN_W-1:0] wld_val;
  logic              chan_run, locked, rld_wr, key_hit, wctl_wr, chstart_wr;
  logic              chan_tick, warn_tick, rst_tick, halted;
  logic              rst_run, expired, expire_evt, warn_en;
  kwd_stat_t         stat;

  assign halted   = halt_code(ctrl_q);
  assign rst_tick = chan_run && (cfg_q[5] ? chan_tick : 1'b1);

  always_comb begin
    stat           = '0;
    stat.warn_flag = warn_irq;
    stat.expired   = expired;
    stat.rst_run   = rst_run;
    stat.chan_run  = chan_run;
  end

  kwd_regs #(.RST_W(RST_W), .WARN_W(WARN_W), .KEY_VAL(KEY_VAL)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rcnt(rcnt), .stat(stat),
    .warn_en(warn_en), .cfg_q(cfg_q), .ctrl_q(ctrl_q), .wpsr_q(wpsr_q),
    .cpsr_q(cpsr_q), .rld_val(rld_val), .rld_next(rld_next), .wld_val(wld_val),
    .chan_run(chan_run), .locked(locked), .rld_wr(rld_wr), .key_hit(key_hit),
    .wctl_wr(wctl_wr), .chstart_wr(chstart_wr)
  );

  kwd_prescale #(.BASE_DIV(BASE_DIV), .CW(PSC_W)) u_chan_psc (
    .clk(clk), .rst_n(rst_n), .run(chan_run), .restart(chstart_wr),
    .sel(cpsr_q[1:0]), .tick(chan_tick)
  );

  kwd_prescale #(.BASE_DIV(BASE_DIV), .CW(PSC_W)) u_warn_psc (
    .clk(clk), .rst_n(rst_n), .run(warn_en), .restart(wctl_wr),
    .sel(wpsr_q[1:0]), .tick(warn_tick)
  );

  kwd_rstcnt #(.RST_W(RST_W)) u_rstcnt (
    .clk(clk), .rst_n(rst_n), .load(rld_wr), .load_val(rld_next),
    .key_hit(key_hit), .reload_val(rld_val), .tick(rst_tick), .halt(halted),
    .rcnt(rcnt), .run(rst_run), .expired(expired), .expire_evt(expire_evt),
    .rst_req(rst_req)
  );

  kwd_warncnt #(.WARN_W(WARN_W)) u_warncnt (
    .clk(clk), .rst_n(rst_n), .ctl_wr(wctl_wr), .ctl_data(bus_wdata[1:0]),
    .load_val(wld_val), .tick(warn_tick), .en(warn_en), .flag(warn_irq)
  );
endmodule

// File: rtl/kwd_chk.sv
module kwd_chk #(
  parameter int unsigned RST_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_req,
  input logic             warn_irq,
  input logic             wctl_wr,
  input logic             rld_wr,
  input logic             key_hit,
  input logic             chan_run,
  input logic             halted,
  input logic             expired,
  input logic             locked,
  input logic             expire_evt,
  input logic [RST_W-1:0] rcnt
);
  // R2
  rst_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R2
  rst_req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(expire_evt));

  // R10
  expired_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> expired);

  // R10
  expired_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> ($stable(rcnt) && !rst_req));

  // R7
  warn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_irq && !wctl_wr) |=> warn_irq);

  // R7
  warn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wctl_wr |=> !warn_irq);

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !rld_wr && !key_hit) |=> $stable(rcnt));

  // R3
  idle_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_run && !rld_wr && !key_hit) |=> ($stable(rcnt) && !rst_req));
endmodule

bind kwd_top kwd_chk #(.RST_W(RST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .warn_irq(warn_irq),
  .wctl_wr(wctl_wr), .rld_wr(rld_wr), .key_hit(key_hit), .chan_run(chan_run),
  .halted(halted), .expired(expired), .locked(locked), .expire_evt(expire_evt),
  .rcnt(rcnt)
);

// File: tb/kwd_top_tb.sv
module kwd_top_tb;
  localparam int unsigned BASE = 2;
  localparam logic [3:0] T_CFG = 4'h0, T_CTRL = 4'h1, T_KEY = 4'h2, T_RLO = 4'h3,
    T_RHI = 4'h4, T_WPSR = 4'h5, T_CPSR = 4'h6, T_CHS = 4'h7, T_W0 = 4'h8,
    T_W1 = 4'h9, T_W2 = 4'hA, T_WCTL = 4'hB, T_CLO = 4'hC, T_CHI = 4'hD, T_STAT = 4'hE;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, warn_irq, rst_req;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  int vecs = 0, errs = 0, pulses = 0;
  bit done = 0;

  always #5 clk = ~clk;

  kwd_top u_dut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .warn_irq(warn_irq), .rst_req(rst_req));

  always @(negedge clk) if (rst_n && rst_req) pulses++;

  function automatic int unsigned f_period(input int unsigned sel);
    return BASE * (1 << sel);
  endfunction
  function automatic int unsigned f_rst_psc_delay(input int unsigned n, input int unsigned sel);
    return n * f_period(sel) - 2;   // start, high byte, low byte issued back to back
  endfunction
  function automatic bit f_key_ok(input bit match, input logic [7:0] v);
    return !match || v == 8'h5C;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask
  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask
  task automatic chk_rd(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask
  task automatic do_reset;
    rst_n = 1'b0; bus_we = 1'b0; idle(2); rst_n = 1'b1; idle(1); pulses = 0;
  endtask
  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [7:0] v;
    seed = $urandom(32'd2024);
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 rst_req", rst_req, 0);
    chk("R1 warn_irq", warn_irq, 0);
    chk_rd("R1 cfg", T_CFG, 8'h00);
    chk_rd("R1 rcnt", T_CLO, 8'h00);
    chk_rd("R11 stat", T_STAT, 8'h00);

    // R2 per-clock expiry timing, R11 status, R10 post-expiry
    wr(T_CFG, 8'h10); wr(T_CHS, 8'h00); wr(T_RHI, 8'h00); wr(T_RLO, 8'd20);
    chk_rd("R11 stat running", T_STAT, 8'h0C);
    idle(5);
    chk_rd("R2 count", T_CLO, 8'd15);
    idle(14);
    chk("R2 before expiry", rst_req, 0);
    idle(1);
    chk("R2 expiry pulse", rst_req, 1);
    idle(1);
    chk("R2 pulse width", rst_req, 0);
    chk_rd("R10 stat expired", T_STAT, 8'h0E);
    wr(T_KEY, 8'h5C); wr(T_RLO, 8'd9); idle(12);
    chk_rd("R10 count frozen", T_CLO, 8'h00);
    chk("R10 single pulse", pulses, 1);

    // R3 no stepping without channel start
    do_reset();
    wr(T_CFG, 8'h10); wr(T_RLO, 8'd10); idle(30);
    chk_rd("R3 count held", T_CLO, 8'd10);
    chk_rd("R3 stat", T_STAT, 8'h04);
    chk("R3 no reset", pulses, 0);

    // R5 key match
    do_reset();
    wr(T_CFG, 8'h10); wr(T_CHS, 8'h00); wr(T_RHI, 8'h00); wr(T_RLO, 8'd40);
    idle(9);
    for (int i = 0; i < 4; i++) begin
      do v = 8'($urandom); while (f_key_ok(1'b1, v));
      wr(T_KEY, v);
    end
    chk_rd("R5 wrong key ignored", T_CLO, 8'd27);
    wr(T_KEY, 8'h5C);
    chk_rd("R5 key reload", T_CLO, 8'd40);
    idle(39);
    chk("R5 no early reset", rst_req, 0);
    idle(1);
    chk("R5 reset after reload", rst_req, 1);

    // R6 key checking off
    do_reset();
    wr(T_CFG, 8'h00); wr(T_CHS, 8'h00); wr(T_RLO, 8'd30); idle(10);
    v = 8'h11;
    if (f_key_ok(1'b0, v)) wr(T_KEY, v);
    chk_rd("R6 any key reloads", T_CLO, 8'd30);

    // R4 prescaled stepping for two selects
    for (int s = 1; s <= 2; s++) begin
      do_reset();
      wr(T_CFG, 8'h30); wr(T_CPSR, 8'(s));
      wr(T_CHS, 8'h00); wr(T_RHI, 8'h00); wr(T_RLO, 8'd6);
      idle(f_rst_psc_delay(6, s) - 1);
      chk("R4 before prescaled expiry", rst_req, 0);
      idle(1);
      chk("R4 prescaled expiry", rst_req, 1);
    end

    // R7 warning timing, stickiness, clearing
    do_reset();
    wr(T_WPSR, 8'h01); wr(T_W2, 8'h00); wr(T_W1, 8'h00); wr(T_W0, 8'd25);
    wr(T_WCTL, 8'h03);
    chk_rd("R11 wctl enable", T_WCTL, 8'h01);
    idle(25 * f_period(1) - 1);
    chk("R7 before warning", warn_irq, 0);
    idle(1);
    chk("R7 warning", warn_irq, 1);
    idle(20);
    chk("R7 sticky", warn_irq, 1);
    chk_rd("R11 stat warn bit", T_STAT, 8'h01);
    wr(T_WCTL, 8'h03);
    chk("R7 cleared", warn_irq, 0);

    // R9 stop control
    do_reset();
    wr(T_CFG, 8'h10); wr(T_CTRL, 8'h03); wr(T_CHS, 8'h00); wr(T_RLO, 8'd50);
    idle(20);
    chk_rd("R9 halted", T_CLO, 8'd50);
    wr(T_CTRL, 8'h02);
    idle(10);
    chk_rd("R9 no stop without permission", T_CLO, 8'd40);

    // R8 locked flow: service while locked, then stall
    do_reset();
    wr(T_CFG, 8'h00); wr(T_WPSR, 8'h01); wr(T_CPSR, 8'h01); wr(T_CFG, 8'h30);
    wr(T_CTRL, 8'h00); wr(T_W2, 8'h00); wr(T_W1, 8'h04); wr(T_W0, 8'h00);
    wr(T_WCTL, 8'h03); wr(T_CHS, 8'h00); wr(T_RHI, 8'h05); wr(T_RLO, 8'h00);
    wr(T_CFG, 8'h3F);
    wr(T_RHI, 8'h01);
    chk_rd("R8 load locked", T_RHI, 8'h05);
    wr(T_CFG, 8'h00);
    chk_rd("R8 cfg locked", T_CFG, 8'h3F);
    for (int k = 0; k < 3; k++) begin
      idle(2000);
      wr(T_WCTL, 8'h03); wr(T_KEY, 8'h5C);
    end
    chk("R8 service keeps reset away", pulses, 0);
    chk("R8 service keeps warning away", warn_irq, 0);
    begin
      int irq_at, rst_at;
      irq_at = -1; rst_at = -1;
      for (int i = 1; i < 6000 && rst_at < 0; i++) begin
        idle(1);
        if (warn_irq && irq_at < 0) irq_at = i;
        if (rst_req && rst_at < 0) rst_at = i;
      end
      chk("R7 warning delay", irq_at, 1024 * f_period(1) - 1);
      chk("R7 warning before reset", (irq_at >= 0) && (irq_at < rst_at), 1);
      chk("R4 reset window", (rst_at >= 1280 * 4 - 5) && (rst_at <= 1280 * 4 + 4), 1);
    end

    // R8 R11 random writes against a shadow with the lock rule
    for (int r = 0; r < 4; r++) begin
      logic [7:0] sh [16];
      do_reset();
      for (int j = 0; j < 16; j++) sh[j] = 8'h00;
      for (int n = 0; n < 40; n++) begin
        logic [3:0] a;
        logic [7:0] d;
        case ($urandom % 8)
          0: a = T_CFG;  1: a = T_CTRL; 2: a = T_RHI; 3: a = T_WPSR;
          4: a = T_CPSR; 5: a = T_W0;   6: a = T_W1;  default: a = T_W2;
        endcase
        d = 8'($urandom);
        if (a == T_CFG && ($urandom % 6) == 0) d[3:0] = 4'hF;
        wr(a, d);
        if (sh[T_CFG][3:0] != 4'hF) sh[a] = d;
        chk_rd("R8 shadow readback", a, sh[a]);
      end
      chk_rd("R11 final cfg", T_CFG, sh[T_CFG]);
      chk_rd("R11 final wld2", T_W2, sh[T_W2]);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule